// File: doc/BRIEF.md
# Quad-Input Flash Page Write Shifter

This block is the host-side master for one page-program transaction on a quad-capable serial flash. A caller pulses `start` together with a device-size select, an address-width select and a start address. The block then drops chip select and sends the 8-bit program command one bit per serial clock on lane 0. After the command, it sends the address and then a stream of data bytes, four bits per serial clock across all four lanes. Data bytes arrive through a valid/ready handshake that has a one-byte holding register. The caller marks the final byte with `byte_last`. Chip select rises when that byte's low nibble is finished.

The serial clock is the system clock divided by `CLK_DIV`, which must be even and at least 2. The serial clock idles low. Lane values change only on serial-clock falling edges, so the flash sees them stable at each rising edge. If the caller has not supplied the next byte when a byte boundary is reached, the serial clock stays low until the byte arrives. Write-enable sequencing, status polling and page-boundary checks belong to the caller.

Top module: `quad_page_writer`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, `dq_oe` is 4'b0000, and `busy` and `byte_ready` are 0.
- R2: The first 8 serial-clock rising edges of a frame carry the command on `dq_out[0]`, most significant bit first, with `dq_oe` = 4'b0001. The command is 8'h12 when `big_dev` = 0 and 8'h38 when `big_dev` = 1.
- R3: With `addr4` = 0, the next 6 rising edges carry address bits [23:0] as nibbles, highest nibble first, with `dq_oe` = 4'b1111. `dq_out[k]` carries bit 4*j+k of the address for nibble j.
- R4: With `addr4` = 1, the address phase carries all 32 address bits as 8 nibbles in the same lane order.
- R5: Each data byte takes two rising edges: first `dq_out` = byte[7:4], then `dq_out` = byte[3:0]. Bytes go out in the order they were accepted.
- R6: `byte_ready` is high while a frame is active, no byte is held and the last byte has not been taken. A byte is accepted on a clock edge where `byte_valid` and `byte_ready` are both high. If no byte is held at a byte boundary, `sclk` stays low and gives no rising edge until one is accepted, and the sent stream is unchanged.
- R7: A frame with N bytes gives exactly 8 + (6 or 8) + 2N rising edges. Chip select rises at the falling edge that ends the last byte. At that point `busy` drops and `done` is high for exactly one system clock.
- R8: While `cs_n` is 1, `dq_oe` is 4'b0000 and `sclk` is 0.
- R9: A `start` pulse during a frame is ignored. The frame keeps the command, width and address captured at its own start, and it produces exactly one `done`.
- R10: One serial-clock period lasts `CLK_DIV` system clocks.
- R11: While chip select stays low, `dq_out` changes only when `sclk` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a frame (used only while idle) |
| big_dev | input | 1 | Command select: 0 gives 8'h12, 1 gives 8'h38 |
| addr4 | input | 1 | 1 selects 32-bit address, 0 selects 24-bit |
| start_addr | input | 32 | Start address (bits [23:0] used when `addr4` = 0) |
| byte_data | input | 8 | Data byte offered by the caller |
| byte_valid | input | 1 | `byte_data` is valid |
| byte_last | input | 1 | The offered byte ends the frame |
| byte_ready | output | 1 | Block can accept a byte this cycle |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse when the frame ends |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| dq_out | output | 4 | Lane output values |
| dq_oe | output | 4 | Per-lane output enables |

## Verification
The hardest case to reach is the byte-boundary stall. The holding register lets the caller run one byte ahead of the shifter, so a late byte only stalls the clock if the caller waits long enough for both the byte in flight and the held byte to drain. The gap scenario offers two bytes at once and then waits long enough for both to drain. It then confirms that no further rising edges occur and that `sclk` sits low. After that it releases the rest of the stream and compares every captured nibble. A second hard case is a `start` pulse during a frame. The test pulses `start` mid-frame with the opposite size, width and address on the inputs and expects the original frame unchanged.

// File: rtl/quad_page_writer.sv
`timescale 1ns/1ps
module quad_page_writer #(
  parameter int        CLK_DIV  = 4,
  parameter logic [7:0] OP_SMALL = 8'h12,
  parameter logic [7:0] OP_LARGE = 8'h38
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        big_dev,
  input  logic        addr4,
  input  logic [31:0] start_addr,
  input  logic [7:0]  byte_data,
  input  logic        byte_valid,
  input  logic        byte_last,
  output logic        byte_ready,
  output logic        busy,
  output logic        done,
  output logic        cs_n,
  output logic        sclk,
  output logic [3:0]  dq_out,
  output logic [3:0]  dq_oe
);
  localparam int HALF = (CLK_DIV < 2) ? 1 : CLK_DIV / 2;
  localparam int DW   = $clog2(HALF) + 1;

  typedef enum logic [2:0] {ST_IDLE, ST_CMD, ST_ADDR, ST_DATA, ST_WAIT} st_t;

  st_t         st;
  logic        sclk_r, cs_r, done_r, wide, cur_last;
  logic        hold_full, hold_last, got_last;
  logic [DW-1:0] div;
  logic [2:0]  slot;
  logic [7:0]  cmd_sh, hold;
  logic [31:0] addr_sh;
  logic [3:0]  lo_nib, dq_r, oe_r;

  wire        running   = (st == ST_CMD) || (st == ST_ADDR) || (st == ST_DATA);
  wire        tick      = running && (div == DW'(HALF - 1));
  wire        fall      = tick && sclk_r;
  wire [2:0]  addr_last = wide ? 3'd7 : 3'd5;
  wire [7:0]  op        = big_dev ? OP_LARGE : OP_SMALL;
  wire        take      = byte_valid && byte_ready;
  wire        nxt_byte  = (fall && st == ST_ADDR && slot == addr_last) ||
                          (fall && st == ST_DATA && slot == 3'd1 && !cur_last) ||
                          (st == ST_WAIT);

  assign byte_ready = (st != ST_IDLE) && !hold_full && !got_last;
  assign busy       = (st != ST_IDLE);
  assign done       = done_r;
  assign cs_n       = cs_r;
  assign sclk       = sclk_r;
  assign dq_out     = dq_r;
  assign dq_oe      = oe_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sclk_r    <= 1'b0;
      cs_r      <= 1'b1;
      done_r    <= 1'b0;
      wide      <= 1'b0;
      cur_last  <= 1'b0;
      hold_full <= 1'b0;
      hold_last <= 1'b0;
      got_last  <= 1'b0;
      div       <= '0;
      slot      <= '0;
      cmd_sh    <= '0;
      hold      <= '0;
      addr_sh   <= '0;
      lo_nib    <= '0;
      dq_r      <= '0;
      oe_r      <= '0;
    end else begin
      done_r <= 1'b0;
      if (take) begin
        hold      <= byte_data;
        hold_last <= byte_last;
        hold_full <= 1'b1;
        if (byte_last) got_last <= 1'b1;
      end
      if (running) div <= tick ? '0 : div + 1'b1;
      if (tick) sclk_r <= ~sclk_r;

      case (st)
        ST_IDLE: if (start) begin
          st       <= ST_CMD;
          cs_r     <= 1'b0;
          oe_r     <= 4'b0001;
          dq_r     <= {3'b000, op[7]};
          cmd_sh   <= {op[6:0], 1'b0};
          addr_sh  <= addr4 ? start_addr : {start_addr[23:0], 8'h00};
          wide     <= addr4;
          slot     <= '0;
          div      <= '0;
          sclk_r   <= 1'b0;
          got_last <= 1'b0;
        end
        ST_CMD: if (fall) begin
          if (slot == 3'd7) begin
            st      <= ST_ADDR;
            slot    <= '0;
            oe_r    <= 4'b1111;
            dq_r    <= addr_sh[31:28];
            addr_sh <= addr_sh << 4;
          end else begin
            slot   <= slot + 1'b1;
            dq_r   <= {3'b000, cmd_sh[7]};
            cmd_sh <= cmd_sh << 1;
          end
        end
        ST_ADDR: if (fall && slot != addr_last) begin
          slot    <= slot + 1'b1;
          dq_r    <= addr_sh[31:28];
          addr_sh <= addr_sh << 4;
        end
        ST_DATA: if (fall) begin
          if (slot == 3'd0) begin
            slot <= 3'd1;
            dq_r <= lo_nib;
          end else if (cur_last) begin
            st     <= ST_IDLE;
            cs_r   <= 1'b1;
            oe_r   <= 4'b0000;
            dq_r   <= 4'b0000;
            done_r <= 1'b1;
          end
        end
        default: ;
      endcase

      if (nxt_byte) begin
        if (hold_full) begin
          st        <= ST_DATA;
          slot      <= '0;
          dq_r      <= hold[7:4];
          lo_nib    <= hold[3:0];
          cur_last  <= hold_last;
          hold_full <= 1'b0;
          div       <= '0;
        end else begin
          st <= ST_WAIT;
        end
      end
    end
  end

  p_idle_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (dq_oe == 4'b0000 && !sclk));

  p_dq_on_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(!cs_n) && !$stable(dq_out)) |-> !sclk);

  p_done_on_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done && cs_n));

  p_oe_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe == 4'b0000 || dq_oe == 4'b0001 || dq_oe == 4'b1111));

  p_stall_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> !sclk);

  p_width_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(wide));
endmodule

// File: tb/test_quad_page_writer.sv
`timescale 1ns/1ps
module test_quad_page_writer;
  localparam int CLK_DIV = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, big_dev = 1'b0, addr4 = 1'b0;
  logic [31:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic byte_valid = 1'b0, byte_last = 1'b0;
  logic byte_ready, busy, done, cs_n, sclk;
  logic [3:0] dq_out, dq_oe;

  int checks = 0, fails = 0;
  int n = 0, done_cnt = 0, bad11 = 0;
  bit finished = 0;
  logic [3:0] rec_dq [0:79];
  logic [3:0] rec_oe [0:79];
  time rec_t [0:79];
  logic [3:0] exp_dq [0:79];
  logic [3:0] exp_oe [0:79];
  logic prev_low = 1'b0;
  logic [3:0] prev_dq = '0;

  always #5 clk = ~clk;

  quad_page_writer #(.CLK_DIV(CLK_DIV)) i_quad_page_writer (
    .clk(clk), .rst_n(rst_n), .start(start), .big_dev(big_dev), .addr4(addr4),
    .start_addr(start_addr), .byte_data(byte_data), .byte_valid(byte_valid),
    .byte_last(byte_last), .byte_ready(byte_ready), .busy(busy), .done(done),
    .cs_n(cs_n), .sclk(sclk), .dq_out(dq_out), .dq_oe(dq_oe));

  always @(posedge sclk) if (!cs_n && n < 80) begin
    rec_dq[n] = dq_out; rec_oe[n] = dq_oe; rec_t[n] = $time; n++;
  end

  always @(negedge clk) begin
    if (done) done_cnt++;
    if (!cs_n && prev_low && dq_out != prev_dq && sclk) bad11++;
    prev_low = !cs_n; prev_dq = dq_out;
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string tag);
    chk("R8", {tag, " cs_n"}, cs_n, 1);
    chk("R8", {tag, " dq_oe"}, dq_oe, 0);
    chk("R8", {tag, " sclk"}, sclk, 0);
  endtask

  task automatic run(input logic big, input logic a4, input logic [31:0] addr,
                     input int nb, input logic [7:0] seed, input int gap, input bit poke);
    logic [7:0] op;
    int na, e, r0;
    op = big ? 8'h38 : 8'h12;
    na = a4 ? 8 : 6;
    e = 0;
    for (int k = 0; k < 8; k++) begin exp_dq[e] = {3'b0, op[7-k]}; exp_oe[e] = 4'b0001; e++; end
    for (int j = 0; j < na; j++) begin exp_dq[e] = addr[4*(na-1-j) +: 4]; exp_oe[e] = 4'hf; e++; end
    for (int i = 0; i < nb; i++) begin
      logic [7:0] b;
      b = seed + 8'(i * 37);
      exp_dq[e] = b[7:4]; exp_oe[e] = 4'hf; e++;
      exp_dq[e] = b[3:0]; exp_oe[e] = 4'hf; e++;
    end
    n = 0; done_cnt = 0; bad11 = 0;
    @(negedge clk);
    big_dev = big; addr4 = a4; start_addr = addr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      big_dev = ~big; addr4 = ~a4; start_addr = ~addr; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < nb; i++) begin
      byte_data = seed + 8'(i * 37);
      byte_valid = 1'b1;
      byte_last = (i == nb - 1);
      while (!byte_ready) @(negedge clk);
      @(negedge clk);
      byte_valid = 1'b0; byte_last = 1'b0;
      if (gap > 0 && i == 1) begin
        repeat (gap) @(negedge clk);
        r0 = n;
        repeat (20) @(negedge clk);
        chk("R6", "edges during stall", n, r0);
        chk("R6", "sclk low during stall", sclk, 0);
        chk("R6", "ready during stall", byte_ready, 1);
      end
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R7", "rising edge count", n, e);
    chk("R7", "done pulses", done_cnt, 1);
    chk("R11", "lane changes with sclk high", bad11, 0);
    check_idle("after frame");
    for (int k = 0; k < e && k < n; k++) begin
      if (k < 8) begin
        chk("R2", $sformatf("cmd bit %0d", k), rec_dq[k][0], exp_dq[k][0]);
        chk("R2", $sformatf("cmd oe %0d", k), rec_oe[k], exp_oe[k]);
      end else if (k < 8 + na) begin
        chk(a4 ? "R4" : "R3", $sformatf("addr nibble %0d", k - 8), rec_dq[k], exp_dq[k]);
        chk(a4 ? "R4" : "R3", $sformatf("addr oe %0d", k - 8), rec_oe[k], exp_oe[k]);
      end else begin
        chk("R5", $sformatf("data nibble %0d", k - 8 - na), rec_dq[k], exp_dq[k]);
      end
    end
  endtask

  task automatic t_reset;
    chk("R1", "cs_n", cs_n, 1);
    chk("R1", "sclk", sclk, 0);
    chk("R1", "dq_oe", dq_oe, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "byte_ready", byte_ready, 0);
  endtask

  task automatic t_small_24;
    run(1'b0, 1'b0, 32'h00A5_C3E1, 4, 8'h5A, 0, 0);
    chk("R10", "sclk period ns", rec_t[1] - rec_t[0], CLK_DIV * 10);
  endtask

  task automatic t_large_32;
    run(1'b1, 1'b1, 32'h9F3C_1B72, 3, 8'hC4, 0, 0);
  endtask

  task automatic t_single_byte;
    run(1'b1, 1'b0, 32'h0012_3456, 1, 8'h81, 0, 0);
  endtask

  task automatic t_stall_gap;
    run(1'b0, 1'b1, 32'h0F1E_2D3C, 5, 8'h27, 40, 0);
  endtask

  task automatic t_busy_start;
    run(1'b0, 1'b0, 32'h0077_8899, 2, 8'hE3, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_small_24();
    t_large_32();
    t_single_byte();
    t_stall_gap();
    t_busy_start();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule